// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a clocked host and a 64K x 16 asynchronous static RAM. The host hands over one word-sized request at a time through a valid/ready handshake: an address, write data, a two-bit lane mask and a read/write flag. The controller converts each request into a timed sequence of active-low strobes on the memory pins and drives the memory's address and data lines. For a read, it registers the returned word and flags it with a one-clock valid pulse.

Each timing margin of the memory is given as a parameter in nanoseconds, alongside a clock-period parameter. Every phase length is the ceiling of the required time divided by the period, and is never less than one clock. At the default 5 ns period the phases are as follows:

| Phase | Length |
|---|---|
| Write strobe | 8 clocks |
| Write recovery | 3 clocks |
| Read access | 11 clocks |
| Read-to-write turnaround | 4 clocks |

Lane masking selects which bytes take part. A mask bit of 1 skips its lane: that lane's byte enable stays high, and the lane reads back as zero.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, `req_ready` is high, `rsp_valid` is low, `mem_dout_en` is low, and every active-low memory strobe (`mem_ce_n`, `mem_we_n`, `mem_oe_n`, both bits of `mem_be_n`) is high.
- R2: A write holds `mem_ce_n` and `mem_we_n` low, `mem_oe_n` high and `mem_dout_en` high with the latched address and data. It does so for N_WP = max(ceil(40/P), ceil(25/P)) clocks, which is 8 at P = 5 ns. During that strobe, `mem_be_n[i]` equals `req_mask[i]`. Bit 1 gates data bits 15:8 and bit 0 gates bits 7:0.
- R3: A write keeps `req_ready` low for N_WC = ceil(55/P) clocks, which is 11 at the default period. That is the strobe plus max(1, N_WC - N_WP) recovery clocks, with the data still driven and `mem_we_n` high. A preceding read turnaround adds to this.
- R4: A read holds `mem_ce_n` and `mem_oe_n` low, `mem_we_n` high and `mem_dout_en` low for N_RD = ceil(55/P) clocks. The word is registered at the last of them. `rsp_valid` is high for exactly one clock as `req_ready` returns. Unmasked lanes carry the memory data and masked lanes read as 0x00.
- R5: A write accepted directly after a read first spends N_HZ = ceil(20/P) clocks with all strobes high and `mem_dout_en` low. A write that follows a write starts its strobe at once.
- R6: A request whose mask is all ones asserts no byte enable and has the same cycle length as an unmasked request. As a write it leaves the memory unchanged; as a read it returns zero.
- R7: `req_ready` is low from the clock after acceptance until the cycle completes. `mem_addr` does not change while `mem_ce_n` stays low.
- R8: Every phase count is the ceiling of its nanosecond figure over the clock period, with a floor of one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request taken this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane skip mask, bit 1 upper byte, bit 0 lower byte |
| rsp_valid | output | 1 | Read data valid, one clock |
| rsp_rdata | output | 16 | Read data, masked lanes zero |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_be_n | output | 2 | Byte enables, active low, bit 1 upper, bit 0 lower |
| mem_addr | output | 16 | Memory address |
| mem_dout | output | 16 | Data toward memory |
| mem_dout_en | output | 1 | Drive enable for `mem_dout` |
| mem_din | input | 16 | Data from memory |

## Verification
The assertions rely on two properties of the inputs:
- Reset is applied before the first request.
- The host's fields matter only in the clock where `req_valid` meets `req_ready`, because the controller latches them there.

The bench holds each request steady from one falling edge until it is accepted, and drops `req_valid` immediately afterwards.

The bench's memory model follows the strobes:
- It commits a write only when the strobe window was at least N_WP clocks long.
- It returns valid read data only after N_RD clocks of read strobe.

A controller that shortens a phase therefore produces visibly wrong data, rather than merely violating a timing margin the assertions do not watch.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_TURN   = 3'd1,
    PH_WPULSE = 3'd2,
    PH_WRECOV = 3'd3,
    PH_READ   = 3'd4
  } phase_e;

  // R8: ceiling of ns over period, never below one clock
  function automatic int unsigned clocks_for(int unsigned ns, int unsigned period);
    int unsigned c;
    c = ns / period;
    if ((ns % period) != 0) c = c + 1;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_gate.sv
module sram_lane_gate #(
  parameter int unsigned LANES = 2
) (
  input  logic               active,
  input  logic [LANES-1:0]   mask,
  input  logic [LANES*8-1:0] din,
  output logic [LANES-1:0]   be_n,
  output logic [LANES*8-1:0] din_gated
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be_n[i]            = !(active && !mask[i]);
    assign din_gated[i*8 +: 8] = mask[i] ? 8'h00 : din[i*8 +: 8];
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CLK_NS  = 5,
  parameter int unsigned T_WC_NS = 55,
  parameter int unsigned T_WP_NS = 40,
  parameter int unsigned T_DS_NS = 25,
  parameter int unsigned T_AA_NS = 55,
  parameter int unsigned T_OE_NS = 25,
  parameter int unsigned T_HZ_NS = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_mask,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                mem_ce_n,
  output logic                mem_we_n,
  output logic                mem_oe_n,
  output logic [DATA_W/8-1:0] mem_be_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_dout,
  output logic                mem_dout_en,
  input  logic [DATA_W-1:0]   mem_din
);
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned N_WP   = max2(clocks_for(T_WP_NS, CLK_NS), clocks_for(T_DS_NS, CLK_NS));
  localparam int unsigned N_WC   = clocks_for(T_WC_NS, CLK_NS);
  localparam int unsigned N_WREC = (N_WC > N_WP) ? (N_WC - N_WP) : 1;
  localparam int unsigned N_RD   = max2(clocks_for(T_AA_NS, CLK_NS), clocks_for(T_OE_NS, CLK_NS));
  localparam int unsigned N_HZ   = clocks_for(T_HZ_NS, CLK_NS);
  localparam int unsigned N_MAX  = max2(max2(N_WP, N_WREC), max2(N_RD, N_HZ));
  localparam int unsigned CW     = $clog2(N_MAX + 1);

  phase_e              phase_q, phase_d;
  logic                rd_last_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   data_q;
  logic [LANES-1:0]    mask_q;
  logic                tmr_load, tmr_last;
  logic [CW-1:0]       tmr_val;
  logic                lanes_on;
  logic [DATA_W-1:0]   din_gated;

  // named events used by the datapath and the assertions
  wire accept    = req_valid && req_ready;
  wire read_done = (phase_q == PH_READ) && tmr_last;
  wire all_off   = &mask_q;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
  );

  sram_lane_gate #(.LANES(LANES)) u_gate (
    .active(lanes_on), .mask(mask_q), .din(mem_din),
    .be_n(mem_be_n), .din_gated(din_gated)
  );

  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (phase_q)
      PH_IDLE: if (accept) begin
        tmr_load = 1'b1;
        if (!req_write) begin
          phase_d = PH_READ;   tmr_val = CW'(N_RD - 1);
        end else if (rd_last_q) begin
          phase_d = PH_TURN;   tmr_val = CW'(N_HZ - 1);
        end else begin
          phase_d = PH_WPULSE; tmr_val = CW'(N_WP - 1);
        end
      end
      PH_TURN: if (tmr_last) begin
        phase_d = PH_WPULSE; tmr_load = 1'b1; tmr_val = CW'(N_WP - 1);
      end
      PH_WPULSE: if (tmr_last) begin
        phase_d = PH_WRECOV; tmr_load = 1'b1; tmr_val = CW'(N_WREC - 1);
      end
      PH_WRECOV: if (tmr_last) phase_d = PH_IDLE;
      PH_READ:   if (tmr_last) phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      rd_last_q <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      mask_q    <= '1;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      phase_q   <= phase_d;
      rsp_valid <= read_done;
      if (accept) begin
        addr_q    <= req_addr;
        data_q    <= req_wdata;
        mask_q    <= req_mask;
        rd_last_q <= 1'b0;
      end
      if (read_done) begin
        rsp_rdata <= din_gated;
        rd_last_q <= 1'b1;
      end
    end
  end

  assign req_ready   = (phase_q == PH_IDLE);
  assign lanes_on    = (phase_q == PH_WPULSE) || (phase_q == PH_READ);
  assign mem_ce_n    = !((phase_q == PH_WPULSE) || (phase_q == PH_WRECOV) || (phase_q == PH_READ));
  assign mem_we_n    = (phase_q != PH_WPULSE);
  assign mem_oe_n    = (phase_q != PH_READ);
  assign mem_dout_en = (phase_q == PH_WPULSE) || (phase_q == PH_WRECOV);
  assign mem_addr    = addr_q;
  assign mem_dout    = data_q;

  // ---------------- assertions ----------------
  logic [CW:0] wlow_len_q;
  logic [CW:0] oe_hi_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wlow_len_q  <= '0;
      oe_hi_len_q <= (CW+1)'(N_HZ);
    end else begin
      wlow_len_q <= mem_we_n ? '0 : wlow_len_q + 1'b1;
      if (!mem_oe_n)                        oe_hi_len_q <= '0;
      else if (oe_hi_len_q < (CW+1)'(N_HZ)) oe_hi_len_q <= oe_hi_len_q + 1'b1;
    end
  end

  // R2
  wr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dout_en));
  // R2
  wr_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wlow_len_q == (CW+1)'(N_WP)));
  // R4
  rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_dout_en && !mem_ce_n));
  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R5
  bus_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dout_en) |-> (oe_hi_len_q >= (CW+1)'(N_HZ)));
  // R6
  lanes_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && all_off) |-> (&mem_be_n));
  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
  // R7
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
endmodule

// File: tb/sram_lane_ctrl_test.sv
`timescale 1ns/1ps
module sram_lane_ctrl_test;
  localparam int P = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_mask = 2'b00;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dout_en;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_addr, mem_dout, mem_din;

  sram_lane_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_dout_en(mem_dout_en), .mem_din(mem_din)
  );

  int checks = 0, fails = 0;

  // R8: bench form of the ceiling, counted upward
  function automatic int ceil_clk(int ns);
    int k = 1;
    while (k * P < ns) k++;
    return k;
  endfunction
  function automatic int imax(int a, int b); return (a > b) ? a : b; endfunction

  int nwp, nwc, nrec, nrd, nhz;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] mem_model [logic [15:0]];
  logic [15:0] ref_mem   [logic [15:0]];

  wire wr_act = !mem_ce_n && !mem_we_n && !(&mem_be_n);
  wire rd_act = !mem_ce_n && !mem_oe_n && mem_we_n;
  int  wcnt = 0, rcnt = 0, oe_hi = 100;
  logic wr_prev = 1'b0, den_prev = 1'b0;
  logic [15:0] wa, wd, rd_word = '0;
  logic [1:0]  wb;

  always @(posedge clk) begin
    if (wr_act) begin
      wcnt <= wcnt + 1; wa <= mem_addr; wd <= mem_dout; wb <= mem_be_n;
    end else begin
      if (wr_prev) begin
        logic [15:0] w;
        check(wcnt >= nwp, "R2 write window length", wcnt, nwp);
        if (wcnt >= nwp) begin
          w = mem_model.exists(wa) ? mem_model[wa] : 16'h0000;
          if (!wb[0]) w[7:0]  = wd[7:0];
          if (!wb[1]) w[15:8] = wd[15:8];
          mem_model[wa] = w;
        end
      end
      wcnt <= 0;
    end
    wr_prev <= wr_act;
    rcnt    <= rd_act ? rcnt + 1 : 0;
    rd_word <= mem_model.exists(mem_addr) ? mem_model[mem_addr] : 16'h0000;
    if (mem_dout_en && !den_prev)
      check(oe_hi >= nhz, "R5 bus turnaround gap", oe_hi, nhz);
    den_prev <= mem_dout_en;
    oe_hi    <= !mem_oe_n ? 0 : oe_hi + 1;
  end

  always_comb begin
    mem_din = 16'hC3C3;
    if (rd_act) begin
      for (int i = 0; i < 2; i++)
        mem_din[i*8 +: 8] = (mem_be_n[i] || rcnt < nrd - 1) ? 8'hA5 : rd_word[i*8 +: 8];
    end
  end

  // ---------------- reference ----------------
  function automatic logic [15:0] exp_read(logic [15:0] a, logic [1:0] m);
    logic [15:0] w = ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
    if (m[0]) w[7:0]  = 8'h00;
    if (m[1]) w[15:8] = 8'h00;
    return w;
  endfunction

  bit last_read = 1'b0;

  task automatic issue(bit wr, logic [15:0] a, logic [15:0] d, logic [1:0] m);
    int n, exp_len;
    bit turn;
    turn = wr && last_read;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    check(!req_ready, "R7 ready low after accept", req_ready, 0);
    if (wr) begin
      if (turn) begin
        check(mem_we_n && mem_ce_n && !mem_dout_en, "R5 turnaround strobes idle",
              {mem_ce_n, mem_we_n, mem_dout_en}, 3'b110);
      end else begin
        check(!mem_we_n && !mem_ce_n && mem_oe_n && mem_dout_en, "R2 write strobes",
              {mem_ce_n, mem_we_n, mem_oe_n, mem_dout_en}, 4'b0011);
        check(mem_be_n == m, (m == 2'b11) ? "R6 no byte enable" : "R2 byte enables",
              mem_be_n, m);
        check(mem_addr == a && mem_dout == d, "R2 address and data", {mem_addr, mem_dout}, {a, d});
      end
      exp_len = (turn ? nhz : 0) + nwp + nrec;
    end else begin
      check(!mem_oe_n && !mem_ce_n && mem_we_n && !mem_dout_en, "R4 read strobes",
            {mem_ce_n, mem_we_n, mem_oe_n, mem_dout_en}, 4'b0100);
      exp_len = nrd;
    end
    while (!req_ready && n < 1000) begin @(negedge clk); n++; end
    check(n == exp_len + 1, wr ? "R3 R8 write cycle length" : "R4 R8 read cycle length",
          n, exp_len + 1);
    if (wr) begin
      if (!m[0]) ref_mem[a][7:0]  = d[7:0];
      if (!m[1]) ref_mem[a][15:8] = d[15:8];
      if (m != 2'b11 && !ref_mem.exists(a)) ref_mem[a] = 16'h0000;
      check(!rsp_valid, "R4 no valid on write", rsp_valid, 0);
    end else begin
      check(rsp_valid && rsp_rdata == exp_read(a, m),
            (m == 2'b11) ? "R6 masked read data" : "R4 read data",
            {rsp_valid, rsp_rdata}, {1'b1, exp_read(a, m)});
      @(negedge clk);
      check(!rsp_valid, "R4 valid one clock", rsp_valid, 0);
    end
    last_read = !wr;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    nwp  = imax(ceil_clk(40), ceil_clk(25));
    nwc  = ceil_clk(55);
    nrec = (nwc > nwp) ? nwc - nwp : 1;
    nrd  = imax(ceil_clk(55), ceil_clk(25));
    nhz  = ceil_clk(20);
    seed = $urandom(32'd20240607);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(req_ready && !rsp_valid && !mem_dout_en && mem_ce_n && mem_we_n && mem_oe_n &&
          mem_be_n == 2'b11, "R1 reset state",
          {req_ready, rsp_valid, mem_dout_en, mem_ce_n, mem_we_n, mem_oe_n, mem_be_n}, 8'h9F);

    // directed corners
    issue(1'b1, 16'h0000, 16'h1234, 2'b00);
    issue(1'b1, 16'hFFFF, 16'hBEEF, 2'b00);   // write after write, no turnaround
    issue(1'b0, 16'h0000, 16'h0000, 2'b00);
    issue(1'b1, 16'h0000, 16'hAB77, 2'b01);   // R5 turnaround, upper lane only
    issue(1'b0, 16'h0000, 16'h0000, 2'b00);
    issue(1'b1, 16'h0000, 16'h99CD, 2'b10);   // lower lane only
    issue(1'b0, 16'h0000, 16'h0000, 2'b00);
    issue(1'b1, 16'h0000, 16'h5555, 2'b11);   // R6 all lanes skipped
    issue(1'b0, 16'h0000, 16'h0000, 2'b00);
    issue(1'b0, 16'h0000, 16'h0000, 2'b11);   // R6 masked read
    issue(1'b0, 16'hFFFF, 16'h0000, 2'b10);

    // constrained random
    for (int k = 0; k < 80; k++) begin
      logic [15:0] a;
      a = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 12);
      issue(1'($urandom % 2), a, 16'($urandom), 2'($urandom % 4));
    end

    repeat (4) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule